// File: doc/BRIEF.md
# Per-pin GPIO interrupt detector

This block watches 32 already-synchronized pin levels and turns selected conditions on them into pending interrupt flags. Every pin owns a control register whose 4-bit mode field picks what counts as an event on that pin. The choices are none, the pin being low, the pin being high, a rising transition, a falling transition, or any transition. Events latch into a shared flag register that software clears by writing ones. A single interrupt line to the processor is high while any flag is pending.

Software drives a simple register bus. A write strobe, a byte address and a 32-bit write word take effect on the clock edge where the strobe is high. Read data is combinational from the address. The block moves no data stream, so no port uses valid/ready. The bus, the pins, the flag vector and the interrupt line are all plain level signals with no back-pressure.

A transition is found by comparing the current pin sample with the sample taken one clock earlier. A flag set by an event appears on the outputs one clock after the edge that saw the event.

Top module: `pin_irq_detector`

## Requirements
- R1: After reset every flag is 0, the interrupt line is 0, and every control register reads back 0.
- R2: The control register of pin n is at byte address n*4. Its mode field is bits 19:16, and the other bits read as 0. A read of an address that maps to nothing returns 0, and 0xA0 is excluded from this because R6 maps it.
- R3: Mode code 0x0 and every code outside {0x8, 0x9, 0xA, 0xB, 0xC} never set the pin's flag.
- R4: Code 0x8 sets the flag on every clock where the pin is 0. Code 0xC sets the flag on every clock where the pin is 1.
- R5: Code 0x9 sets the flag when the pin goes 0 to 1, code 0xA when it goes 1 to 0, and code 0xB on either change. Each edge is judged against the previous clock's sample, and the flag is visible one clock after the sampling edge.
- R6: The flag register is at byte address 0xA0, with bit n for pin n and reads returning the flags. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and writing all ones clears every flag.
- R7: When an event and a clear hit the same bit on the same edge, the bit ends up set. A level mode whose level is still active therefore keeps its flag set through a clear.
- R8: The interrupt output is 1 exactly when at least one flag is set.
- R9: Writing 0 to a pin's control register stops that pin from raising further flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 32 | Synchronized pin levels |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| status_o | output | 32 | Pending flag vector |
| irq_o | output | 1 | Combined interrupt, OR of all flags |

## Verification
Several rules are checked on every clock by the assertions. A flag may only appear after an event. An event always leaves its bit set, even against a clear. A clear without an event leaves the bit at zero. Disabled or undefined codes produce no event, edge events require a pin change, a control write reads back its field, and pending flags keep the interrupt high. The bench scenarios are needed for the rest: the exact meaning of each mode code on real pin waveforms, the address map and read-back masking, and level flags persisting through clears. They also cover masking by a zero write and the cycle in which a flag first becomes visible.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF  = 4'h0,
    MODE_LOW  = 4'h8,
    MODE_RISE = 4'h9,
    MODE_FALL = 4'hA,
    MODE_ANY  = 4'hB,
    MODE_HIGH = 4'hC
  } irq_mode_e;
endpackage

// File: rtl/pin_irq_regfile.sv
module pin_irq_regfile
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS      = 32,
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter int MODE_LSB      = 16,
  parameter int STATUS_OFFSET = 160
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [DATA_W-1:0]                  wdata,
  input  logic [NUM_PINS-1:0]                status_i,
  output logic [NUM_PINS-1:0][MODE_W-1:0]    mode_o,
  output logic [NUM_PINS-1:0]                clr_o,
  output logic [DATA_W-1:0]                  rdata_o
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STATUS_OFFSET);

  logic [NUM_PINS-1:0][MODE_W-1:0] mode_q;
  logic                            stat_hit;

  assign stat_hit = (addr == STAT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_en) begin
      for (int n = 0; n < NUM_PINS; n++) begin
        if (addr == ADDR_W'(n * 4)) begin
          mode_q[n] <= wdata[MODE_LSB +: MODE_W];
        end
      end
    end
  end

  assign mode_o = mode_q;
  assign clr_o  = (wr_en && stat_hit) ? wdata[NUM_PINS-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (stat_hit) begin
      rdata_o[NUM_PINS-1:0] = status_i;
    end
    for (int n = 0; n < NUM_PINS; n++) begin
      if (addr == ADDR_W'(n * 4)) begin
        rdata_o[MODE_LSB +: MODE_W] = mode_q[n];
      end
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && wr_en && (addr == ADDR_W'(g * 4)))
        |-> mode_q[g] == $past(wdata[MODE_LSB +: MODE_W])); // R2
  end
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_PINS-1:0]             pins_i,
  input  logic [NUM_PINS-1:0][MODE_W-1:0] mode_i,
  output logic [NUM_PINS-1:0]             event_o
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pins_i;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic cur;
    logic old;
    logic fire;

    assign cur = pins_i[g];
    assign old = prev_q[g];

    always_comb begin
      case (mode_i[g])
        MODE_LOW:  fire = !cur;
        MODE_HIGH: fire = cur;
        MODE_RISE: fire = cur && !old;
        MODE_FALL: fire = !cur && old;
        MODE_ANY:  fire = cur ^ old;
        default:   fire = 1'b0;
      endcase
    end

    assign event_o[g] = fire;

    AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_i[g][MODE_W-1] |-> !event_o[g]); // R3
    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i[g] == MODE_RISE || mode_i[g] == MODE_FALL || mode_i[g] == MODE_ANY)
        && event_o[g]) |-> pins_i[g] != $past(pins_i[g])); // R5
  end
endmodule

// File: rtl/pin_irq_flags.sv
module pin_irq_flags #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] event_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] flags_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_i) | event_i;
  end

  assign flags_o = flag_q;
  assign irq_o   = |flag_q;

  AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & ~$past(flag_q) & ~$past(event_i)) == '0); // R4
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(event_i) & ~flag_q) == '0); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_i & ~event_i) & flag_q) == '0); // R6
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_q) != '0 && $past(clr_i) == '0) |-> irq_o); // R8
endmodule

// File: rtl/pin_irq_detector.sv
module pin_irq_detector
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS      = 32,
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter int MODE_LSB      = 16,
  parameter int STATUS_OFFSET = 160
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                bus_wr_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] status_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0][MODE_W-1:0] mode;
  logic [NUM_PINS-1:0]             clr;
  logic [NUM_PINS-1:0]             evt;
  logic [NUM_PINS-1:0]             flags;

  pin_irq_regfile #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MODE_LSB(MODE_LSB), .STATUS_OFFSET(STATUS_OFFSET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .status_i(flags), .mode_o(mode), .clr_o(clr),
    .rdata_o(bus_rdata)
  );

  pin_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .mode_i(mode), .event_o(evt)
  );

  pin_irq_flags #(.NUM_PINS(NUM_PINS)) u_flags (
    .clk(clk), .rst_n(rst_n), .event_i(evt), .clr_i(clr),
    .flags_o(flags), .irq_o(irq_o)
  );

  assign status_o = flags;
endmodule

// File: tb/tb_pin_irq_detector.sv
module tb_pin_irq_detector;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] status;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [3:0]  m_mode [NP];
  logic [31:0] m_prev, m_flags, m_ev, m_clr;
  logic [3:0]  codes [8] = '{4'h0, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'h3, 4'hF};

  pin_irq_detector dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_wr_en(wr_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .status_o(status), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic fires(logic [3:0] m, logic cur, logic prv);
    case (m)
      4'h8: return !cur;
      4'hC: return cur;
      4'h9: return cur && !prv;
      4'hA: return !cur && prv;
      4'hB: return cur ^ prv;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model, built from the requirements; reads only bench-driven inputs.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) m_mode[i] = 4'h0;
      m_prev  = '0;
      m_flags = '0;
    end else begin
      for (int i = 0; i < NP; i++) m_ev[i] = fires(m_mode[i], pins[i], m_prev[i]);
      m_clr   = (wr_en && addr == 8'hA0) ? wdata : '0;
      m_flags = (m_flags & ~m_clr) | m_ev;
      if (wr_en && addr[1:0] == 2'b00 && addr < 8'd128) m_mode[addr >> 2] = wdata[19:16];
      m_prev = pins;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R4 R5 R6 R7 status vs model", status, m_flags);
      check("R8 irq vs model", {31'b0, irq}, {31'b0, |m_flags});
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finished = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 status after reset", status, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h00, d); check("R1 ctrl pin0 reads 0", d, 32'h0);
    rd(8'h7C, d); check("R1 ctrl pin31 reads 0", d, 32'h0);
    rd(8'hA0, d); check("R1 flags read 0", d, 32'h0);

    // R2 address map and field masking
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); check("R2 only mode field kept", d, 32'h000F_0000);
    rd(8'h90, d); check("R2 unmapped reads 0", d, 32'h0);
    wr(8'h14, 32'h0);

    // R5 rising on pin 3
    wr(8'h0C, 32'h0009_0000);
    pins[3] = 1'b1; tick();
    check("R5 rise sets flag", status & 32'h8, 32'h8);
    check("R8 irq high with flag", {31'b0, irq}, 32'h1);
    pins[3] = 1'b0; tick();
    check("R5 fall ignored in rise mode", status, 32'h8);
    wr(8'hA0, 32'h8);
    check("R6 w1c clears bit", status, 32'h0);
    check("R8 irq low when clear", {31'b0, irq}, 32'h0);

    // R7 event and clear on the same edge
    pins[3] = 1'b1; wr(8'hA0, 32'h8);
    check("R7 event beats clear", status, 32'h8);
    wr(8'hA0, 32'h8);
    check("R6 clear after collision", status, 32'h0);

    // R5 falling on pin 4, either edge on pin 6
    wr(8'h10, 32'h000A_0000);
    pins[4] = 1'b1; tick();
    check("R5 rise ignored in fall mode", status & 32'h10, 32'h0);
    pins[4] = 1'b0; tick();
    check("R5 fall sets flag", status & 32'h10, 32'h10);
    wr(8'h18, 32'h000B_0000);
    pins[6] = 1'b1; tick();
    check("R5 any-edge on rise", status & 32'h40, 32'h40);
    wr(8'hA0, 32'h40);
    pins[6] = 1'b0; tick();
    check("R5 any-edge on fall", status & 32'h40, 32'h40);
    wr(8'hA0, 32'hFFFF_FFFF);
    check("R6 all ones clears all", status, 32'h0);

    // R4 level low on pin 7, level high on pin 8
    wr(8'h1C, 32'h0008_0000);
    tick();
    check("R4 low level flags", status & 32'h80, 32'h80);
    wr(8'hA0, 32'h80);
    check("R7 level still active re-flags", status & 32'h80, 32'h80);
    pins[7] = 1'b1; wr(8'hA0, 32'h80);
    check("R4 low flag clears once high", status & 32'h80, 32'h0);
    wr(8'h20, 32'h000C_0000);
    check("R4 high mode quiet while low", status & 32'h100, 32'h0);
    pins[8] = 1'b1; tick();
    check("R4 high level flags", status & 32'h100, 32'h100);
    pins[8] = 1'b0; wr(8'hA0, 32'h0);
    check("R6 writing zero keeps flag", status & 32'h100, 32'h100);
    wr(8'hA0, 32'hFFFF_FEFF);
    check("R6 other ones keep flag", status & 32'h100, 32'h100);
    rd(8'hA0, d); check("R6 flags readable", d & 32'h100, 32'h100);
    wr(8'hA0, 32'hFFFF_FFFF);
    check("R8 irq low after full clear", {31'b0, irq}, 32'h0);

    // R9 masking by zero write
    wr(8'h0C, 32'h0);
    pins[3] = 1'b0; tick(); pins[3] = 1'b1; tick();
    check("R9 masked pin quiet", status & 32'h8, 32'h0);

    // R3 undefined codes
    wr(8'h10, 32'h0005_0000);
    pins[4] = 1'b1; tick(); pins[4] = 1'b0; tick();
    check("R3 code 5 quiet", status & 32'h10, 32'h0);
    wr(8'h10, 32'h000F_0000);
    pins[4] = 1'b1; tick(); pins[4] = 1'b0; tick();
    check("R3 code F quiet", status & 32'h10, 32'h0);

    // Random phase, checked against the model every cycle
    for (int c = 0; c < 3000; c++) begin
      int sel;
      pins = pins ^ ($urandom & $urandom & $urandom);
      sel = $urandom % 5;
      if (sel == 0) begin
        d = $urandom;
        d[19:16] = codes[$urandom % 8];
        wr(8'(($urandom % NP) * 4), d);
      end else if (sel == 1) begin
        wr(8'hA0, $urandom & $urandom);
      end else begin
        tick();
      end
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule